// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Model

This block is a clocked, synthesizable stand-in for a byte-wide memory that can be programmed once. A fresh part reads all ones. Programming can only clear bits, so a location's stored byte is the bitwise AND of every byte ever programmed into it. The block is controlled by two active-low strobes, a chip select (`ce_n`) and an output gate (`oe_n`). Two digital flags replace analog levels: `prog_supply` marks the high programming supply, and `id_level` marks the high identification voltage on an address pin.

Each cycle the block works out its operating mode from the strobes and flags. The modes are read, output off, standby, program, verify, inhibit and identifier readout. The data bus is presented as `dout` together with a separate `dout_en`, so a parked (high-impedance) bus can be seen directly. A programming pulse is a stretch of cycles with `ce_n` low while the supply flag is set and `oe_n` is high. The byte is written when `ce_n` returns high, using the address and data present in that cycle. Reset clears only the output registers. Stored contents survive reset, as a non-volatile array would.

Top module: `otp_byte_mem`

## Requirements
- R1: With `prog_supply`=0 and `id_level`=0, `ce_n`=0 and `oe_n`=0 give `dout_en`=1 and `dout` equal to the stored byte at `addr`.
- R2: With `prog_supply`=0, `ce_n`=1 (standby) or `ce_n`=0 with `oe_n`=1 (output off) gives `dout_en`=0 and `dout`=00h.
- R3: With `prog_supply`=1, one or more cycles of `ce_n`=0 and `oe_n`=1 followed by a cycle of `ce_n`=1, `oe_n`=1, `prog_supply`=1 performs one write. The write uses the `addr` and `din` of that final cycle.
- R4: Every location reads FFh before it is first programmed. A write stores the old byte ANDed with `din`, so a bit once cleared never returns to 1.
- R5: With `prog_supply`=1, `ce_n`=1 and `oe_n`=0 (verify) give `dout_en`=1 and `dout` equal to the stored byte.
- R6: With `prog_supply`=1, `ce_n`=1 and `oe_n`=1 (inhibit) give `dout_en`=0. A pulse that ends with `oe_n`=0 writes nothing.
- R7: With `id_level`=1, `prog_supply`=0, `ce_n`=0, `oe_n`=0 and every address bit above bit 0 low, `dout` is 20h when `addr[0]`=0 and B4h when `addr[0]`=1, with `dout_en`=1 and `id_err`=0.
- R8: In identifier mode with any address bit above bit 0 high, `dout` is FFh with `dout_en`=1 and `id_err`=1. In every other mode `id_err`=0.
- R9: Outputs are registered and show the inputs sampled two rising clock edges earlier. Reset forces `dout_en`=0, `dout`=00h and `id_err`=0 and leaves stored bytes unchanged.
- R10: With `prog_supply`=1, `ce_n`=0 together with `oe_n`=0 drives nothing (`dout_en`=0). Raising `ce_n` after that state writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| ce_n | input | 1 | Active-low chip select; its low pulse is the program strobe |
| oe_n | input | 1 | Active-low output gate |
| prog_supply | input | 1 | High programming supply present |
| id_level | input | 1 | High identification level present on the address pin |
| addr | input | AW | Byte address, AW = clog2(DEPTH) |
| din | input | 8 | Byte to program |
| dout | output | 8 | Data bus value, 00h while parked |
| dout_en | output | 1 | Bus driven (1) or high-impedance (0) |
| id_err | output | 1 | Identifier requested with a non-zero upper address |

## Verification
Programming is tried in three ways. Repeated writes to one address, with falling bit patterns and an all-ones byte, show whether the block ANDs or overwrites. A pulse whose address changes before `ce_n` rises shows whether the address is taken at the start or at the end of the pulse. Pulses that end in verify, or that start with both strobes low, tell a real write apart from a supply-only glitch. Identifier reads at addresses 0 to 3 separate the two code bytes from the error case. Back-to-back reads of different addresses, plus a reset in the middle of the run, confirm the two-edge latency and that reset leaves the contents alone.

// File: rtl/otp_pkg.sv
package otp_pkg;

  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] MFR_CODE  = 8'h20;
  localparam logic [BYTE_W-1:0] DEV_CODE  = 8'hB4;
  localparam logic [BYTE_W-1:0] BLANK     = 8'hFF;
  localparam logic [BYTE_W-1:0] BAD_IDENT = 8'hFF;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_OUT_OFF,
    MD_READ,
    MD_IDENT,
    MD_PROGRAM,
    MD_VERIFY,
    MD_INHIBIT,
    MD_CLASH
  } op_mode_t;

  // Modes that put a value on the data bus
  function automatic logic drives_bus(input op_mode_t m);
    return (m == MD_READ) || (m == MD_VERIFY) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     prog_supply,
  input  logic     id_level,
  output op_mode_t mode
);

  always_comb begin
    if (!prog_supply) begin
      if (ce_n)
        mode = MD_STANDBY;
      else if (oe_n)
        mode = MD_OUT_OFF;
      else if (id_level)
        mode = MD_IDENT;
      else
        mode = MD_READ;
    end else begin
      unique case ({ce_n, oe_n})
        2'b01:   mode = MD_PROGRAM;
        2'b10:   mode = MD_VERIFY;
        2'b11:   mode = MD_INHIBIT;
        default: mode = MD_CLASH;
      endcase
    end
  end

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  op_mode_t          mode,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic              wr_go,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_mask
);

  // armed: the previous cycle was a valid program pulse cycle
  logic armed;
  logic fire;

  // Pulse ends cleanly only when the next state is inhibit
  assign fire = armed && (mode == MD_INHIBIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      wr_go <= 1'b0;
    end else begin
      armed <= (mode == MD_PROGRAM);
      wr_go <= fire;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      wr_addr <= addr;
      wr_mask <= din;
    end
  end

  AST_WRITE_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_go |-> ($past(mode) == MD_INHIBIT && $past(mode, 2) == MD_PROGRAM)); // R3

  AST_ONE_WRITE_PER_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> !wr_go); // R3

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array
  import otp_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned AW    = 10
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_go,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_mask
);

  logic [BYTE_W-1:0] cells [DEPTH];

  // Erased state as initial content
  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = BLANK;
  end

  // Synchronous read port. In the cycle after a write is accepted, rd_data
  // still holds the byte read at the accepting edge, which is the old byte
  // at wr_addr.
  always @(posedge clk) begin
    rd_data <= cells[rd_addr];
    if (wr_go)
      cells[wr_addr] <= rd_data & wr_mask;
  end

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
  import otp_pkg::*;
#(
  parameter  int unsigned DEPTH = 1024,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              prog_supply,
  input  logic              id_level,
  input  logic [AW-1:0]     addr,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_en,
  output logic              id_err
);

  op_mode_t          mode;
  op_mode_t          md_q;
  logic              dev_sel_q;
  logic              hi_bits_q;
  logic [BYTE_W-1:0] rd_data;
  logic              wr_go;
  logic [AW-1:0]     wr_addr;
  logic [BYTE_W-1:0] wr_mask;

  otp_mode_dec u_dec (
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .prog_supply (prog_supply),
    .id_level    (id_level),
    .mode        (mode)
  );

  otp_prog_ctrl #(.AW(AW)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .addr    (addr),
    .din     (din),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask)
  );

  otp_cell_array #(.DEPTH(DEPTH), .AW(AW)) u_cells (
    .clk     (clk),
    .rd_addr (addr),
    .rd_data (rd_data),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask)
  );

  // Stage 1: capture the mode next to the array read
  always_ff @(posedge clk) begin
    if (rst) begin
      md_q      <= MD_STANDBY;
      dev_sel_q <= 1'b0;
      hi_bits_q <= 1'b0;
    end else begin
      md_q      <= mode;
      dev_sel_q <= addr[0];
      hi_bits_q <= |addr[AW-1:1];
    end
  end

  // Stage 2: registered bus
  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_en <= 1'b0;
      id_err  <= 1'b0;
    end else begin
      unique case (md_q)
        MD_READ, MD_VERIFY: begin
          dout    <= rd_data;
          dout_en <= 1'b1;
          id_err  <= 1'b0;
        end
        MD_IDENT: begin
          dout    <= hi_bits_q ? BAD_IDENT : (dev_sel_q ? DEV_CODE : MFR_CODE);
          dout_en <= 1'b1;
          id_err  <= hi_bits_q;
        end
        default: begin
          dout    <= '0;
          dout_en <= 1'b0;
          id_err  <= 1'b0;
        end
      endcase
    end
  end

  AST_DRIVE_ONLY_READ_MODES: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> drives_bus($past(md_q))); // R1

  AST_PARKED_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !drives_bus(md_q) |=> (!dout_en && dout == '0)); // R2

  AST_ID_CODE_VALUES: assert property (@(posedge clk) disable iff (rst)
    (dout_en && !id_err && $past(md_q) == MD_IDENT) |->
      (dout == MFR_CODE || dout == DEV_CODE)); // R7

  AST_ID_ERR_SCOPE: assert property (@(posedge clk) disable iff (rst)
    id_err |-> (dout == BAD_IDENT && dout_en && $past(md_q) == MD_IDENT)); // R8

  AST_SUPPLY_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
    prog_supply |-> !(mode == MD_READ || mode == MD_IDENT)); // R10

endmodule

// File: tb/otp_byte_mem_bench.sv
module otp_byte_mem_bench;
  import otp_pkg::*;

  localparam int unsigned DEPTH = 1024;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, prog_supply = 1'b0, id_level = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en, id_err;

  otp_byte_mem #(.DEPTH(DEPTH)) u_otp_byte_mem (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n),
    .prog_supply(prog_supply), .id_level(id_level),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .id_err(id_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic [7:0] model [DEPTH];

  typedef struct {
    logic       en;
    logic [7:0] d;
    logic       er;
    int         due;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic compare(input logic en, input logic [7:0] d, input logic er, input string tag);
    checks++;
    if (dout_en !== en || dout !== d || id_err !== er) begin
      errors++;
      $display("FAIL %s: got en=%0b data=%02h err=%0b expected en=%0b data=%02h err=%0b",
               tag, dout_en, dout, id_err, en, d, er);
    end
  endtask

  // Monitor: pops expectations when their cycle arrives
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      compare(e.en, e.d, e.er, e.tag);
    end
  end

  task automatic step(input logic c, input logic o, input logic p, input logic i,
                      input int a, input logic [7:0] d);
    @(negedge clk);
    ce_n = c; oe_n = o; prog_supply = p; id_level = i;
    addr = AW'(a); din = d;
  endtask

  task automatic probe(input logic c, input logic o, input logic p, input logic i,
                       input int a, input logic en, input logic [7:0] d,
                       input logic er, input string tag);
    exp_t e;
    step(c, o, p, i, a, 8'h00);
    e.en = en; e.d = d; e.er = er; e.due = cyc + 2; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic read_chk(input int a, input string tag);
    probe(1'b0, 1'b0, 1'b0, 1'b0, a, 1'b1, model[a], 1'b0, tag);
  endtask

  task automatic prog_byte(input int a, input logic [7:0] d);
    step(1'b0, 1'b1, 1'b1, 1'b0, a, d);
    step(1'b1, 1'b1, 1'b1, 1'b0, a, d);
    step(1'b1, 1'b1, 1'b0, 1'b0, a, d);
    model[a] = model[a] & d;
  endtask

  task automatic drain();
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
    while (sb.size() > 0) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) model[k] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare(1'b0, 8'h00, 1'b0, "R9 reset state");
    rst = 1'b0;

    // R1 / R4: erased reads, two addresses back to back (R9 latency)
    read_chk(5, "R4 erased byte reads FFh");
    read_chk(6, "R1 read erased neighbour");

    // R3 / R4: program and accumulate
    prog_byte(5, 8'hA5);
    read_chk(5, "R3 first program");
    prog_byte(5, 8'h0F);
    read_chk(5, "R4 AND with old byte");
    prog_byte(5, 8'hFF);
    read_chk(5, "R4 ones cannot restore");

    // R5 verify
    probe(1'b1, 1'b0, 1'b1, 1'b0, 5, 1'b1, 8'h05, 1'b0, "R5 verify drives stored");

    // R2 / R6 parked modes
    probe(1'b0, 1'b1, 1'b0, 1'b0, 5, 1'b0, 8'h00, 1'b0, "R2 output off");
    probe(1'b1, 1'b0, 1'b0, 1'b0, 5, 1'b0, 8'h00, 1'b0, "R2 standby");
    probe(1'b1, 1'b1, 1'b1, 1'b0, 5, 1'b0, 8'h00, 1'b0, "R6 inhibit parked");

    // R3: address taken at the end of the pulse
    step(1'b0, 1'b1, 1'b1, 1'b0, 10, 8'h3C);
    step(1'b0, 1'b1, 1'b1, 1'b0, 11, 8'h3C);
    step(1'b1, 1'b1, 1'b1, 1'b0, 11, 8'h3C);
    step(1'b1, 1'b1, 1'b0, 1'b0, 0, 8'h00);
    model[11] = 8'h3C;
    read_chk(11, "R3 end-of-pulse address written");
    read_chk(10, "R3 start address untouched");

    // R6: pulse ending in verify writes nothing
    step(1'b0, 1'b1, 1'b1, 1'b0, 20, 8'h00);
    step(1'b1, 1'b0, 1'b1, 1'b0, 20, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b0, 20, 8'h00);
    read_chk(20, "R6 verify-ended pulse no write");

    // R10: both strobes low under supply
    probe(1'b0, 1'b0, 1'b1, 1'b0, 30, 1'b0, 8'h00, 1'b0, "R10 clash parked");
    step(1'b1, 1'b1, 1'b1, 1'b0, 30, 8'h00);
    step(1'b1, 1'b1, 1'b0, 1'b0, 30, 8'h00);
    read_chk(30, "R10 clash no write");

    // R7 / R8 identifier
    probe(1'b0, 1'b0, 1'b0, 1'b1, 0, 1'b1, 8'h20, 1'b0, "R7 maker code");
    probe(1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b1, 8'hB4, 1'b0, "R7 device code");
    probe(1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1, 8'hFF, 1'b1, "R8 upper bit set");
    probe(1'b0, 1'b0, 1'b0, 1'b1, 3, 1'b1, 8'hFF, 1'b1, "R8 upper bit with bit0");
    probe(1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b0, 8'h00, 1'b0, "R8 no error outside ident");
    drain();

    // R9: reset mid-run keeps contents
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    compare(1'b0, 8'h00, 1'b0, "R9 reset clears outputs");
    rst = 1'b0;
    read_chk(5, "R9 contents kept over reset");
    read_chk(11, "R9 second byte kept over reset");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule